// File: doc/BRIEF.md
# Banked External Interrupt Trigger Controller

This block gathers peripheral interrupt lines, organised in banks of 32, and steers each one onto one of several per-thread CPU trigger outputs. Every line has a sense setting that selects edge capture or level pass-through. It also has an enable bit and a routing code that names its destination thread. Each bank keeps a status word. Software reads it to see which lines are pending and writes ones into it to toggle bits. Toggling lets software clear a captured edge or raise a line again by hand.

Software reaches all state through a single-cycle 32-bit register port: a valid strobe, a write flag, a byte address and write data, with read data returned one cycle later. Each thread's trigger is active-low and level-sensitive. It is held low while any line that is pending, enabled and routed to that thread remains set. The bank count, the thread count and the presence of enable registers are build-time parameters.

Top module: `eitc_top`

## Requirements
- R1: After reset every status, sense, enable and routing register reads zero, so every line is edge-sensed, disabled and unrouted, and every trig_n bit is 1.
- R2: Line n belongs to bank n>>5 at bit n&31. Bank b has its status word at byte address 8*b, its sense word at 0x40+8*b and its enable word at 0x80+8*b. The routing register of line n is at 0x1000*((n>>5)+1) + 8*(n&31), and only its low $clog2(NUM_THREADS+1) bits are stored.
- R3: On an edge-sensed line (sense bit 0), a rising input sets the status bit on the third clock edge after the input changes. The bit then stays set after the input falls.
- R4: Writing 1 to a status bit of an edge-sensed line inverts that bit. Writing 0 to a status bit leaves it unchanged.
- R5: On a level-sensed line (sense bit 1), the status bit follows the input with the same three-edge latency. A write of 1 to that status bit forces it set for exactly one cycle.
- R6: If a captured rising edge and a toggle write hit the same status bit on the same clock edge, the bit ends up set.
- R7: An enable bit of 0 keeps its line from every trigger, and 1 lets it through. When HAS_MASK is 0 the enable words read zero, writes to them are ignored, and every line counts as enabled.
- R8: A routing code k with 1 <= k <= NUM_THREADS sends the line to trig_n[k-1] and to no other trigger. A code of 0, or any code above NUM_THREADS, connects the line to no trigger.
- R9: trig_n[t] is 0 exactly while at least one line has its status set, is enabled and carries routing code t+1. The output changes in the same cycle as the register state it depends on.
- R10: Reads of unmapped addresses return zero, and writes to them change nothing. Unmapped addresses include addresses not aligned to 8 bytes, the reserved region 0xC0–0xFF, and banks or routing blocks at or above NUM_BANKS.
- R11: Read data appears on bus_rdata on the clock edge that accepts the read, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_BANKS*32 | Asynchronous peripheral interrupt lines, active high |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| trig_n | output | NUM_THREADS | Per-thread aggregated trigger, active low |

## Verification
The main instance is built with four banks, four threads and enable registers present. This reaches the top bank at line 127, every routing block, and the 3-bit routing codes 5 to 7 that lie above the thread count. A second instance uses one bank, two threads and no enable registers. With that build, bank 1 and routing block 2 become unmapped, enable writes become dead, and the 2-bit code 3 falls out of range. Random rounds then mix sense settings, enables, routing codes, input patterns and toggle writes on the full-size build.

// File: rtl/eitc_pkg.sv
package eitc_pkg;
    localparam int BANK_LINES = 32;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 32;
    localparam int LINE_IDX_W = 7;

    typedef enum logic [1:0] {
        RGN_STATUS = 2'd0,
        RGN_SENSE  = 2'd1,
        RGN_ENABLE = 2'd2,
        RGN_RSVD   = 2'd3
    } bank_rgn_e;
endpackage

// File: rtl/eitc_sync.sv
module eitc_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;
endmodule

// File: rtl/eitc_bank.sv
module eitc_bank
    import eitc_pkg::*;
#(
    parameter bit HAS_MASK = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BANK_LINES-1:0] line_lvl,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  stat_wr,
    input  logic                  sense_wr,
    input  logic                  mask_wr,
    output logic [BANK_LINES-1:0] status,
    output logic [BANK_LINES-1:0] sense,
    output logic [BANK_LINES-1:0] mask
);
    logic [BANK_LINES-1:0] prev_q;
    logic [BANK_LINES-1:0] stat_q;
    logic [BANK_LINES-1:0] sense_q;
    logic [BANK_LINES-1:0] rise;
    logic [BANK_LINES-1:0] wr_bits;
    logic [BANK_LINES-1:0] stat_d;

    always_comb begin
        rise    = line_lvl & ~prev_q;
        wr_bits = stat_wr ? wdata : '0;
        // level lines: follow input, write forces a one-cycle set
        // edge lines: a captured rise wins over a toggle
        stat_d  = (sense_q & (line_lvl | wr_bits))
                | (~sense_q & (rise | (stat_q ^ wr_bits)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            stat_q  <= '0;
            sense_q <= '0;
        end else begin
            prev_q <= line_lvl;
            stat_q <= stat_d;
            if (sense_wr) begin
                sense_q <= wdata;
            end
        end
    end

    generate
        if (HAS_MASK) begin : g_mask
            logic [BANK_LINES-1:0] mask_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mask_q <= '0;
                end else if (mask_wr) begin
                    mask_q <= wdata;
                end
            end
            assign mask = mask_q;
        end else begin : g_nomask
            assign mask = '0;
        end
    endgenerate

    assign status = stat_q;
    assign sense  = sense_q;
endmodule

// File: rtl/eitc_route.sv
module eitc_route #(
    parameter int NUM_LINES   = 128,
    parameter int NUM_THREADS = 4,
    parameter int VEC_W       = 3
) (
    input  logic [NUM_LINES-1:0]            pend,
    input  logic [NUM_LINES-1:0][VEC_W-1:0] vec,
    output logic [NUM_THREADS-1:0]          trig_n
);
    generate
        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int i = 0; i < NUM_LINES; i++) begin
                    if (pend[i] && (vec[i] == VEC_W'(t + 1))) begin
                        hit = 1'b1;
                    end
                end
            end
            assign trig_n[t] = ~hit;
        end
    endgenerate
endmodule

// File: rtl/eitc_top.sv
module eitc_top
    import eitc_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int NUM_THREADS = 4,
    parameter bit HAS_MASK    = 1'b1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_BANKS*BANK_LINES-1:0] irq_in,
    input  logic                            bus_valid,
    input  logic                            bus_write,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic [DATA_W-1:0]               bus_rdata,
    output logic [NUM_THREADS-1:0]          trig_n
);
    localparam int NUM_LINES = NUM_BANKS * BANK_LINES;
    localparam int VEC_W     = $clog2(NUM_THREADS + 1);

    logic [NUM_LINES-1:0] sync_q;
    logic [NUM_LINES-1:0] stat_q;
    logic [NUM_LINES-1:0] sense_q;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] line_en;
    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0][VEC_W-1:0] vec_q;

    logic                  wr_en;
    logic                  rd_en;
    logic [2:0]            sel_bank;
    bank_rgn_e             sel_rgn;
    logic                  bank_hit;
    logic [3:0]            vec_blk;
    logic [3:0]            vec_blk_m1;
    logic                  vec_hit;
    logic [LINE_IDX_W-1:0] vec_line;
    logic [DATA_W-1:0]     rd_next;

    eitc_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (sync_q)
    );

    always_comb begin
        wr_en      = bus_valid & bus_write;
        rd_en      = bus_valid & ~bus_write;
        sel_bank   = bus_addr[5:3];
        sel_rgn    = bank_rgn_e'(bus_addr[7:6]);
        bank_hit   = (bus_addr[15:8] == 8'd0) && (bus_addr[2:0] == 3'd0)
                   && (int'(sel_bank) < NUM_BANKS) && (sel_rgn != RGN_RSVD);
        vec_blk    = bus_addr[15:12];
        vec_blk_m1 = vec_blk - 4'd1;
        vec_hit    = (vec_blk != 4'd0) && (int'(vec_blk) <= NUM_BANKS)
                   && (bus_addr[11:8] == 4'd0) && (bus_addr[2:0] == 3'd0);
        vec_line   = {vec_blk_m1[1:0], bus_addr[7:3]};
    end

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic here;
            assign here = wr_en && bank_hit && (sel_bank == 3'(b));
            eitc_bank #(.HAS_MASK(HAS_MASK)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .line_lvl (sync_q[b*BANK_LINES +: BANK_LINES]),
                .wdata    (bus_wdata),
                .stat_wr  (here && (sel_rgn == RGN_STATUS)),
                .sense_wr (here && (sel_rgn == RGN_SENSE)),
                .mask_wr  (here && (sel_rgn == RGN_ENABLE)),
                .status   (stat_q[b*BANK_LINES +: BANK_LINES]),
                .sense    (sense_q[b*BANK_LINES +: BANK_LINES]),
                .mask     (mask_q[b*BANK_LINES +: BANK_LINES])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (wr_en && vec_hit) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (vec_line == LINE_IDX_W'(i)) begin
                    vec_q[i] <= bus_wdata[VEC_W-1:0];
                end
            end
        end
    end

    assign line_en = HAS_MASK ? mask_q : '1;
    assign pend    = stat_q & line_en;

    eitc_route #(
        .NUM_LINES   (NUM_LINES),
        .NUM_THREADS (NUM_THREADS),
        .VEC_W       (VEC_W)
    ) u_route (
        .pend   (pend),
        .vec    (vec_q),
        .trig_n (trig_n)
    );

    always_comb begin
        rd_next = '0;
        if (bank_hit) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (sel_bank == 3'(b)) begin
                    unique case (sel_rgn)
                        RGN_STATUS: rd_next = stat_q[b*BANK_LINES +: BANK_LINES];
                        RGN_SENSE:  rd_next = sense_q[b*BANK_LINES +: BANK_LINES];
                        RGN_ENABLE: rd_next = mask_q[b*BANK_LINES +: BANK_LINES];
                        default:    rd_next = '0;
                    endcase
                end
            end
        end else if (vec_hit) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (vec_line == LINE_IDX_W'(i)) begin
                    rd_next = DATA_W'(vec_q[i]);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_en) begin
            bus_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/eitc_chk.sv
module eitc_chk #(
    parameter int NUM_LINES   = 128,
    parameter int NUM_THREADS = 4,
    parameter bit HAS_MASK    = 1'b1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_valid,
    input logic                   bus_write,
    input logic [31:0]            bus_rdata,
    input logic [NUM_LINES-1:0]   stat,
    input logic [NUM_LINES-1:0]   sense,
    input logic [NUM_LINES-1:0]   mask,
    input logic [NUM_LINES-1:0]   lvl,
    input logic [NUM_THREADS-1:0] trig_n
);
    // R9: nothing pending means every trigger is released
    p_idle_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == '0) |-> (&trig_n));

    // R7: with enables present and all cleared, no trigger is driven
    p_mask_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_MASK && (mask == '0)) |-> (&trig_n));

    // R3: a captured edge is never lost without a write
    p_edge_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write) |=> ((($past(stat) & ~$past(sense)) & ~stat) == '0));

    // R5: level lines follow the synchronised input when not written
    p_level_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write) |=> (((stat ^ $past(lvl)) & $past(sense)) == '0));

    // R11: read data holds between reads
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));
endmodule

bind eitc_top eitc_chk #(
    .NUM_LINES   (NUM_BANKS * 32),
    .NUM_THREADS (NUM_THREADS),
    .HAS_MASK    (HAS_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_rdata (bus_rdata),
    .stat      (stat_q),
    .sense     (sense_q),
    .mask      (mask_q),
    .lvl       (sync_q),
    .trig_n    (trig_n)
);

// File: tb/eitc_top_tb_top.sv
module eitc_top_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] irq = '0;
    logic         b_valid = 1'b0, b_write = 1'b0;
    logic [15:0]  b_addr = '0;
    logic [31:0]  b_wdata = '0;
    logic [31:0]  b_rdata;
    logic [3:0]   trig;
    logic [31:0]  n_irq = '0;
    logic         n_valid = 1'b0, n_write = 1'b0;
    logic [15:0]  n_addr = '0;
    logic [31:0]  n_wdata = '0;
    logic [31:0]  n_rdata;
    logic [1:0]   n_trig;

    int n_chk = 0;
    int n_fail = 0;

    bit [127:0] m_stat, m_sense, m_mask, m_in;
    bit [2:0]   m_vec [128];

    always #2 clk = ~clk;

    eitc_top #(.NUM_BANKS(4), .NUM_THREADS(4), .HAS_MASK(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_valid(b_valid), .bus_write(b_write),
        .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(b_rdata), .trig_n(trig));

    eitc_top #(.NUM_BANKS(1), .NUM_THREADS(2), .HAS_MASK(1'b0)) dut_nm_i (
        .clk(clk), .rst_n(rst_n), .irq_in(n_irq), .bus_valid(n_valid), .bus_write(n_write),
        .bus_addr(n_addr), .bus_wdata(n_wdata), .bus_rdata(n_rdata), .trig_n(n_trig));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        if (!sel) begin b_valid = 1; b_write = 1; b_addr = a; b_wdata = d; end
        else      begin n_valid = 1; n_write = 1; n_addr = a; n_wdata = d; end
        @(posedge clk);
        @(negedge clk);
        b_valid = 0; n_valid = 0;
    endtask

    task automatic rd(input bit sel, input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        if (!sel) begin b_valid = 1; b_write = 0; b_addr = a; end
        else      begin n_valid = 1; n_write = 0; n_addr = a; end
        @(posedge clk);
        @(negedge clk);
        b_valid = 0; n_valid = 0;
        d = sel ? n_rdata : b_rdata;
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] a_stat(int b);  return 16'(8 * b);        endfunction
    function automatic logic [15:0] a_sense(int b); return 16'(64 + 8 * b);   endfunction
    function automatic logic [15:0] a_mask(int b);  return 16'(128 + 8 * b);  endfunction
    function automatic logic [15:0] a_vec(int l);
        return 16'(4096 * (l / 32 + 1) + 8 * (l % 32));
    endfunction

    function automatic logic [3:0] exp_trig();
        logic [3:0] r = 4'hF;
        for (int i = 0; i < 128; i++)
            if (m_stat[i] && m_mask[i] && m_vec[i] != 0 && m_vec[i] <= 4) r[m_vec[i] - 1] = 1'b0;
        return r;
    endfunction

    task automatic do_reset();
        rst_n = 0; irq = '0; n_irq = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_stat = '0; m_sense = '0; m_mask = '0; m_in = '0;
        for (int i = 0; i < 128; i++) m_vec[i] = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd715));
        do_reset();

        // R1 reset state
        check("R1 trig after reset", 32'(trig), 32'hF);
        rd(0, a_stat(0), d);   check("R1 status reset", d, 0);
        rd(0, a_sense(3), d);  check("R1 sense reset", d, 0);
        rd(0, a_mask(1), d);   check("R1 enable reset", d, 0);
        rd(0, a_vec(127), d);  check("R1 route reset", d, 0);

        // R2 / R11 address map and read hold
        wr(0, a_sense(3), 32'hA5A5_0000);
        rd(0, a_sense(3), d);  check("R2 sense bank3 readback", d, 32'hA5A5_0000);
        wait_neg(3);           check("R11 rdata holds", b_rdata, 32'hA5A5_0000);
        wr(0, a_sense(3), 32'h0);

        // R10 unmapped
        wr(0, 16'h0060, 32'hFFFF_FFFF);
        wr(0, 16'h5000, 32'h7);
        wr(0, 16'h0044, 32'hFFFF_FFFF);
        wr(0, 16'h00C0, 32'hFFFF_FFFF);
        rd(0, 16'h0060, d);    check("R10 bank4 read", d, 0);
        rd(0, 16'h5000, d);    check("R10 route block5 read", d, 0);
        rd(0, 16'h0044, d);    check("R10 misaligned read", d, 0);
        rd(0, 16'h00C0, d);    check("R10 reserved read", d, 0);
        rd(0, a_sense(0), d);  check("R10 sense0 untouched", d, 0);
        rd(0, a_sense(3), d);  check("R10 sense3 untouched", d, 0);
        check("R10 trig untouched", 32'(trig), 32'hF);

        // R3 edge capture on line 40 (bank1 bit8) routed to thread 1
        wr(0, a_vec(40), 32'd2);
        rd(0, a_vec(40), d);   check("R2 route line40 readback", d, 2);
        wr(0, a_mask(1), 32'h100);
        @(negedge clk); irq[40] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R3 not yet after two edges", 32'(trig), 32'hF);
        @(posedge clk); @(negedge clk);
        check("R3 set on third edge", 32'(trig), 32'hD);
        irq[40] = 1'b0;
        wait_neg(5);
        check("R3 sticky after input fall", 32'(trig), 32'hD);
        rd(0, a_stat(1), d);   check("R3 status bank1", d, 32'h100);

        // R4 toggle
        wr(0, a_stat(1), 32'h0);
        rd(0, a_stat(1), d);   check("R4 zero write no effect", d, 32'h100);
        wr(0, a_stat(1), 32'h100);
        check("R4 toggle clears trig", 32'(trig), 32'hF);
        rd(0, a_stat(1), d);   check("R4 toggle clears", d, 0);
        wr(0, a_stat(1), 32'h100);
        rd(0, a_stat(1), d);   check("R4 toggle sets", d, 32'h100);
        check("R9 re-raised trig", 32'(trig), 32'hD);

        // R7 enable
        wr(0, a_mask(1), 32'h0);
        check("R7 disabled blocks", 32'(trig), 32'hF);
        wr(0, a_mask(1), 32'h100);
        check("R7 enabled passes", 32'(trig), 32'hD);

        // R8 routing codes
        wr(0, a_vec(40), 32'd0);
        check("R8 code 0 disconnects", 32'(trig), 32'hF);
        wr(0, a_vec(40), 32'd5);
        check("R8 code 5 out of range", 32'(trig), 32'hF);
        wr(0, a_vec(40), 32'd4);
        check("R8 code 4 drives only trig3", 32'(trig), 32'h7);
        wr(0, a_stat(1), 32'h100);
        check("R4 cleared again", 32'(trig), 32'hF);

        // R5 level line 3 routed to thread 0
        wr(0, a_sense(0), 32'h8);
        wr(0, a_mask(0), 32'h8);
        wr(0, a_vec(3), 32'd1);
        @(negedge clk); irq[3] = 1'b1;
        wait_neg(5);
        check("R5 level high drives", 32'(trig), 32'hE);
        rd(0, a_stat(0), d);   check("R5 status follows high", d, 32'h8);
        irq[3] = 1'b0;
        wait_neg(5);
        check("R5 level low releases", 32'(trig), 32'hF);
        rd(0, a_stat(0), d);   check("R5 status follows low", d, 0);
        wr(0, a_stat(0), 32'h8);
        check("R5 forced set cycle", 32'(trig), 32'hE);
        @(posedge clk); @(negedge clk);
        check("R5 force lasts one cycle", 32'(trig), 32'hF);

        // R6 edge and toggle collide on line 40 (status already set)
        irq[40] = 1'b1; wait_neg(5);
        irq[40] = 1'b0; wait_neg(5);
        check("R6 primed", 32'(trig), 32'h7);
        irq[40] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        b_valid = 1; b_write = 1; b_addr = a_stat(1); b_wdata = 32'h100;
        @(posedge clk); @(negedge clk);
        b_valid = 0;
        rd(0, a_stat(1), d);   check("R6 hardware set wins", d, 32'h100);
        check("R6 trig stays", 32'(trig), 32'h7);

        // second build: one bank, two threads, no enables
        wr(1, 16'h1028, 32'd2);
        wr(1, 16'h0080, 32'hFFFF_FFFF);
        rd(1, 16'h0080, d);    check("R7 absent enable reads zero", d, 0);
        @(negedge clk); n_irq[5] = 1'b1;
        wait_neg(5);
        check("R7 absent enable passes line", 32'(n_trig), 32'h1);
        rd(1, 16'h0008, d);    check("R10 bank1 unmapped small build", d, 0);
        rd(1, 16'h2000, d);    check("R10 route block2 unmapped small build", d, 0);
        wr(1, 16'h1028, 32'd3);
        check("R8 code 3 out of range small build", 32'(n_trig), 32'h3);

        // random rounds on the full build
        do_reset();
        for (int it = 0; it < 60; it++) begin
            int l, b, b2;
            logic [2:0] v;
            logic [31:0] w;
            logic [127:0] nin;
            l = int'($urandom_range(127, 0));
            v = 3'($urandom);
            wr(0, a_vec(l), 32'(v)); m_vec[l] = v;
            b = int'($urandom_range(3, 0));
            w = $urandom;
            wr(0, a_sense(b), w); m_sense[b*32 +: 32] = w;
            m_stat = (m_stat & ~m_sense) | (m_in & m_sense);
            b2 = int'($urandom_range(3, 0));
            w = $urandom;
            wr(0, a_mask(b2), w); m_mask[b2*32 +: 32] = w;
            nin = {$urandom, $urandom, $urandom, $urandom};
            @(negedge clk); irq = nin;
            wait_neg(5);
            m_stat = (m_sense & nin) | (~m_sense & (m_stat | (nin & ~m_in)));
            m_in = nin;
            check("R9 random trigger", 32'(trig), 32'(exp_trig()));
            rd(0, a_stat(l / 32), d);
            check("R3 R5 random status", d, m_stat[(l/32)*32 +: 32]);
            w = $urandom;
            wr(0, a_stat(b), w);
            m_stat[b*32 +: 32] = m_stat[b*32 +: 32] ^ (w & ~m_sense[b*32 +: 32]);
            wait_neg(2);
            rd(0, a_stat(b), d);
            check("R4 random toggle", d, m_stat[b*32 +: 32]);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule